// File: doc/BRIEF.md
# Indexed framebuffer memory scheduler

This block lives in the fast memory clock domain of a video path. Frames are buffered in external SDRAM: a video source writes them, and a display engine reads them back at its own rate. On its source side the block reads 4-bit colour indices from a show-ahead FIFO. It collects them four at a time into a 16-bit word and writes each word to memory with a single request. On its display side it fetches one 16-bit word at a time and hands its four indices, one per cycle, to the display FIFO. It keeps separate word counters for writing and reading, and each counter wraps at the frame size.

Every memory access moves exactly one word, and an access is only started once its data is complete or has somewhere to go. The FIFOs on either side therefore need nothing beyond plain empty and full flags. A write needs four pixels already held, and a read needs the unpack register to be empty. When both could go, the read goes first, so that the display side is never starved. The frame size is a parameter, given in pixels, and it must be a multiple of four.

Top module: `fb_index_scheduler`

## Requirements
- R1: After reset, no memory request is issued, no display push occurs and no source pixel is popped. The first read and the first write both use word address 0.
- R2: Each group of four accepted pixels is written as one word. The first pixel goes in bits [3:0], the second in [7:4], the third in [11:8] and the fourth in [15:12]. A group with fewer than four pixels is never written.
- R3: A source pixel is popped only while the source FIFO is not empty and fewer than four pixels are held. A write is requested only with a full word held.
- R4: The display side gets the indices of a word starting with bits [3:0] and ending with [15:12]. A push only happens while the display FIFO is not full.
- R5: A read is requested only once the unpack register is empty. While the display FIFO stays full, at most one word is prefetched.
- R6: If a read and a write are both eligible, the read is issued. With both sides streaming, reads and writes alternate, so a write waits at most one access.
- R7: Only one request is outstanding at a time. A request is a one-cycle pulse on `mem_req`, and address, direction and write data stay stable until `mem_done`. Read data is taken only on the `mem_rvalid` strobe.
- R8: Each counter advances by one word per access and wraps from PIXELS/4-1 to 0.
- R9: A pixel flagged start-of-frame becomes the first pixel of a new group whose word is written to address 0. Any partial group held at that time is discarded.
- R10: A frame that has been written reads back on the display side bit-exactly and in pixel order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_empty | input | 1 | Source FIFO holds no pixel |
| src_pix | input | 4 | Colour index at the source FIFO head |
| src_sof | input | 1 | Head pixel starts a new frame |
| src_pop | output | 1 | Consume the source FIFO head this cycle |
| dst_full | input | 1 | Display FIFO cannot take a pixel |
| dst_push | output | 1 | Write `dst_pix` into the display FIFO this cycle |
| dst_pix | output | 4 | Colour index toward the display |
| mem_req | output | 1 | One-cycle request pulse |
| mem_we | output | 1 | 1 = write, 0 = read, held for the access |
| mem_addr | output | clog2(PIXELS/4) | Word address, held for the access |
| mem_wdata | output | 16 | Packed word for a write, held for the access |
| mem_done | input | 1 | Access complete |
| mem_rvalid | input | 1 | `mem_rdata` is valid this cycle |
| mem_rdata | input | 16 | Word read from memory |

## Verification
A pixel on the source side is consumed at the rising edge where `src_pop` is high. The write request carrying the fourth pixel of a group rises on the following edge. A word taken on `mem_rvalid` shows its first index on `dst_pix` right after that edge and its last index three pushes later, and each later request follows the edge that sees `mem_done` by one cycle. The bench's memory model raises `mem_rvalid` one cycle ahead of `mem_done` and puts garbage on the data bus at the `mem_done` cycle, so a capture in the wrong cycle corrupts the stream. Stimulus changes on falling edges, and every output is sampled one or two time units later, well before the next rising edge that acts on it. The scoreboard compares each display push against the queued pixel order.

// File: rtl/fb_index_scheduler.sv
module fb_index_scheduler #(
  parameter  int PIXELS = 307200,
  localparam int WORDS  = PIXELS / 4,
  localparam int AW     = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_empty,
  input  logic [3:0]    src_pix,
  input  logic          src_sof,
  output logic          src_pop,
  input  logic          dst_full,
  output logic          dst_push,
  output logic [3:0]    dst_pix,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic          mem_done,
  input  logic          mem_rvalid,
  input  logic [15:0]   mem_rdata
);

  logic [15:0]   pk;
  logic [2:0]    pk_cnt;
  logic [15:0]   ub;
  logic [2:0]    ub_cnt;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          busy;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a);
    return (a == AW'(WORDS - 1)) ? '0 : a + 1'b1;
  endfunction

  wire pk_full  = (pk_cnt == 3'd4);
  wire ub_empty = (ub_cnt == 3'd0);
  wire rd_go    = !busy && ub_empty;
  wire wr_go    = !busy && pk_full && !ub_empty;

  assign src_pop  = !src_empty && !pk_full;
  assign dst_push = !ub_empty && !dst_full;
  assign dst_pix  = ub[3:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pk     <= '0;
      pk_cnt <= '0;
      wr_ptr <= '0;
    end else if (src_pop) begin
      if (src_sof) begin
        pk     <= {12'd0, src_pix};
        pk_cnt <= 3'd1;
        wr_ptr <= '0;
      end else begin
        pk[{pk_cnt[1:0], 2'b00} +: 4] <= src_pix;
        pk_cnt <= pk_cnt + 3'd1;
      end
    end else if (wr_go) begin
      pk_cnt <= '0;
      wr_ptr <= step(wr_ptr);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rd_ptr    <= '0;
      busy      <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      if (busy) begin
        if (mem_done) busy <= 1'b0;
      end else if (rd_go) begin
        mem_req  <= 1'b1;
        mem_we   <= 1'b0;
        mem_addr <= rd_ptr;
        rd_ptr   <= step(rd_ptr);
        busy     <= 1'b1;
      end else if (wr_go) begin
        mem_req   <= 1'b1;
        mem_we    <= 1'b1;
        mem_addr  <= wr_ptr;
        mem_wdata <= pk;
        busy      <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ub     <= '0;
      ub_cnt <= '0;
    end else if (busy && !mem_we && mem_rvalid) begin
      ub     <= mem_rdata;
      ub_cnt <= 3'd4;
    end else if (dst_push) begin
      ub     <= {4'd0, ub[15:4]};
      ub_cnt <= ub_cnt - 3'd1;
    end
  end

endmodule

// File: rtl/fb_index_scheduler_chk.sv
module fb_index_scheduler_chk #(
  parameter  int PIXELS = 307200,
  localparam int WORDS  = PIXELS / 4,
  localparam int AW     = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [15:0]   mem_wdata,
  input logic          mem_done,
  input logic [2:0]    pk_cnt,
  input logic [2:0]    ub_cnt
);

  logic          outst;
  logic          seen_rd;
  logic [AW-1:0] last_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outst   <= 1'b0;
      seen_rd <= 1'b0;
      last_rd <= '0;
    end else begin
      if (mem_req) outst <= 1'b1;
      else if (mem_done) outst <= 1'b0;
      if (mem_req && !mem_we) begin
        seen_rd <= 1'b1;
        last_rd <= mem_addr;
      end
    end
  end

  a_r7_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !outst);

  a_r7_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (outst && !mem_done) |=> ($stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r8_addr_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (int'(mem_addr) < WORDS));

  a_r8_read_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && seen_rd) |-> (int'(mem_addr) == ((int'(last_rd) + 1) % WORDS)));

  a_r6_read_first: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ($past(ub_cnt) != 3'd0));

  a_r3_full_word_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ($past(pk_cnt) == 3'd4));

  a_r5_read_when_drained: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> ($past(ub_cnt) == 3'd0));

endmodule

bind fb_index_scheduler fb_index_scheduler_chk #(.PIXELS(PIXELS)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_done(mem_done),
  .pk_cnt(pk_cnt), .ub_cnt(ub_cnt)
);

// File: tb/tb_fb_index_scheduler.sv
module tb_fb_index_scheduler;
  localparam int CLK_PERIOD = 10;
  localparam int PIX   = 32;
  localparam int WORDS = PIX / 4;

  logic clk = 1'b0;
  logic rst_n;
  logic src_empty, src_sof, src_pop;
  logic [3:0] src_pix;
  logic dst_full, dst_push;
  logic [3:0] dst_pix;
  logic mem_req, mem_we, mem_done, mem_rvalid;
  logic [2:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  fb_index_scheduler #(.PIXELS(PIX)) dut (
    .clk(clk), .rst_n(rst_n),
    .src_empty(src_empty), .src_pix(src_pix), .src_sof(src_sof), .src_pop(src_pop),
    .dst_full(dst_full), .dst_push(dst_push), .dst_pix(dst_pix),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_done(mem_done), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int nchecks = 0, nfail = 0;
  int nreq = 0, nwr = 0;
  bit log_we [1024];
  int log_addr [1024];
  int wlog [256];
  logic [15:0] mem_m [WORDS];
  logic [3:0] exp_q [$];
  bit mon_en = 1'b0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] fpix(input int p);
    return 4'((p * 7 + 3) & 15);
  endfunction

  function automatic logic [15:0] init_word(input int i);
    return {4'(i), 4'hC, 4'h5, 4'((i + 9) & 15)};
  endfunction

  // memory model: rvalid one cycle before done, garbage data on the done cycle
  initial begin
    mem_done = 1'b0; mem_rvalid = 1'b0; mem_rdata = 16'hDEAD;
    @(negedge clk);
    forever begin
      if (rst_n === 1'b1 && mem_req === 1'b1) begin
        int a; bit w; logic [15:0] d;
        a = int'(mem_addr); w = mem_we; d = mem_wdata;
        if (nreq < 1024) begin log_we[nreq] = w; log_addr[nreq] = a; end
        nreq++;
        if (w) begin mem_m[a] = d; if (nwr < 256) wlog[nwr] = a; nwr++; end
        @(negedge clk);
        check(mem_req === 1'b0, "R7 request while busy", int'(mem_req), 0);
        @(negedge clk);
        check(mem_req === 1'b0, "R7 request while busy", int'(mem_req), 0);
        if (!w) begin mem_rvalid = 1'b1; mem_rdata = mem_m[a]; end
        @(negedge clk);
        check(int'(mem_addr) == a && mem_we == w, "R7 request held", int'(mem_addr), a);
        mem_rvalid = 1'b0; mem_rdata = 16'hDEAD; mem_done = 1'b1;
        @(negedge clk);
        mem_done = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk); #2;
      if (mon_en && dst_push === 1'b1) begin
        if (exp_q.size() == 0) check(1'b0, "R10 unexpected push", int'(dst_pix), 0);
        else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          check(dst_pix === e, "R4 R10 pixel order", int'(dst_pix), int'(e));
        end
      end
    end
  end

  task automatic send_pix(input logic [3:0] p, input bit sof);
    src_pix = p; src_sof = sof; src_empty = 1'b0;
    forever begin
      #1;
      if (src_pop === 1'b1) break;
      @(negedge clk);
    end
    @(negedge clk);
    src_empty = 1'b1; src_sof = 1'b0;
  endtask

  task automatic wait_writes(input int n);
    for (int k = 0; k < 300; k++) begin
      if (nwr >= n) break;
      @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end

  initial begin
    int n0, k, reads, last_w;
    for (int i = 0; i < WORDS; i++) mem_m[i] = init_word(i);
    rst_n = 1'b0; src_empty = 1'b1; src_pix = 4'd0; src_sof = 1'b0; dst_full = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(mem_req === 1'b0, "R1 reset mem_req", int'(mem_req), 0);
    check(dst_push === 1'b0, "R1 reset dst_push", int'(dst_push), 0);
    check(src_pop === 1'b0, "R1 reset src_pop", int'(src_pop), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    check(nreq == 1, "R5 single prefetch while full", nreq, 1);
    check(log_we[0] == 1'b0 && log_addr[0] == 0, "R1 first read at word 0", log_addr[0], 0);
    check(src_pop === 1'b0, "R3 no pop when empty", int'(src_pop), 0);

    // write one frame while the display side is held off
    for (int p = 0; p < 4; p++) exp_q.push_back(init_word(0)[p*4 +: 4]);
    for (int p = 4; p < PIX; p++) exp_q.push_back(fpix(p));
    for (int p = 0; p < PIX; p++) exp_q.push_back(fpix(p));
    for (int p = 0; p < PIX; p++) send_pix(fpix(p), p == 0);
    wait_writes(WORDS);
    check(nwr == WORDS, "R2 one write per group", nwr, WORDS);
    for (int w = 0; w < WORDS; w++) begin
      logic [15:0] ew;
      ew = {fpix(4*w+3), fpix(4*w+2), fpix(4*w+1), fpix(4*w)};
      check(mem_m[w] === ew, "R2 packing order", int'(mem_m[w]), int'(ew));
      check(wlog[w] == w, "R8 R1 write address sequence", wlog[w], w);
    end

    // read back with intermittent backpressure
    mon_en = 1'b1;
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      if (exp_q.size() == 0) break;
      dst_full = (c % 3 == 2);
    end
    dst_full = 1'b1;
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R10 frame fully read back", exp_q.size(), 0);
    k = 0;
    for (int i = 0; i < nreq && i < 1024; i++) begin
      if (!log_we[i]) begin
        check(log_addr[i] == k % WORDS, "R8 read address wrap", log_addr[i], k % WORDS);
        k++;
      end
    end

    // partial group, then start of frame
    n0 = nwr;
    send_pix(4'hE, 1'b0);
    send_pix(4'hD, 1'b0);
    repeat (10) @(negedge clk);
    check(nwr == n0, "R3 partial group not written", nwr, n0);
    send_pix(4'h1, 1'b1); send_pix(4'h2, 1'b0); send_pix(4'h3, 1'b0); send_pix(4'h4, 1'b0);
    wait_writes(n0 + 1);
    check(nwr == n0 + 1, "R9 one write after sof group", nwr, n0 + 1);
    check(wlog[n0] == 0, "R9 sof group at word 0", wlog[n0], 0);
    check(mem_m[0] === 16'h4321, "R9 partial group discarded", int'(mem_m[0]), 16'h4321);

    // write counter wrap without a new start of frame
    n0 = nwr;
    for (int g = 0; g < WORDS; g++)
      for (int j = 0; j < 4; j++) send_pix(4'((g + j) & 15), 1'b0);
    wait_writes(n0 + WORDS);
    for (int g = 0; g < WORDS; g++)
      check(wlog[n0+g] == (g + 1) % WORDS, "R8 write counter wrap", wlog[n0+g], (g + 1) % WORDS);
    check(mem_m[0] === {4'(WORDS+2), 4'(WORDS+1), 4'(WORDS), 4'(WORDS-1)},
          "R8 wrapped word content", int'(mem_m[0]), int'({4'(WORDS+2), 4'(WORDS+1), 4'(WORDS), 4'(WORDS-1)}));

    // both sides streaming: reads win, accesses alternate
    mon_en = 1'b0;
    n0 = nreq;
    dst_full = 1'b0;
    for (int p = 0; p < 40; p++) send_pix(4'(p & 15), 1'b0);
    repeat (20) @(negedge clk);
    dst_full = 1'b1;
    repeat (10) @(negedge clk);
    last_w = -1; reads = 0;
    for (int i = n0; i < nreq && i < 1024; i++) begin
      if (log_we[i]) begin
        if (last_w >= 0) check(reads == 1, "R6 one read between writes", reads, 1);
        last_w = i; reads = 0;
      end else reads++;
    end
    check(last_w >= 0, "R6 writes seen while streaming", last_w, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule